// File: doc/BRIEF.md
# Serial EEPROM Transaction Controller

This block runs complete two-wire EEPROM transactions on behalf of a local agent. The agent presents one command: an operation code, the 3-bit chip select of the target memory, an 8-bit word address and a byte count. The controller then produces the whole bus sequence. That sequence covers the start and stop conditions, the device and word address phases, and the repeated start for addressed reads. It also covers the data phases and the acknowledge handling.

Write data is pulled from the agent one byte at a time through a valid/ready handshake. While no byte is offered, the controller holds SCL high and waits. Each received byte is handed back with a one-cycle strobe. When the transaction ends, a completion pulse is raised together with an error flag. The flag is set when the target failed to acknowledge or the command was refused.

SCL is driven push-pull from the system clock through a programmable phase length. SDA is an open-drain pull-down enable, and the bus level is read back on a separate input.

Top module: `eeprom_xact_ctrl`

## Requirements
- R1: After reset and whenever no transaction is running, scl_o is 1, sda_oe is 0, cmd_ready is 1 and done is 0. After reset err is also 0.
- R2: Every accepted, non-refused command opens with a start (SDA falling while SCL is high) and closes with exactly one stop (SDA rising while SCL is high). Random and sequential reads contain exactly one more start (the repeated start). At all other times SDA changes only while SCL is low.
- R3: Every SCL low phase lasts exactly div+2 system clocks. Address and data bytes are sent most significant bit first.
- R4: Operation code 0 (byte write) sends the device byte {1010, cmd_dev, 0}, then the word address, then one data byte. The data byte is taken at a rising clock edge where wr_valid and wr_ready are both 1. A stop follows.
- R5: Operation code 1 (page write) with cmd_len from 1 to 8 takes exactly cmd_len bytes through the handshake. These bytes land at consecutive word addresses starting at cmd_addr.
- R6: A command is refused when it has any of these properties: operation code above 4, a page write with cmd_len of 0 or above 8, or a sequential read with cmd_len of 0. A refused command causes no SCL or SDA activity. done and err are 1 in the cycle after acceptance.
- R7: Operation code 2 (current address read) sends only the device byte {1010, cmd_dev, 1} and receives one byte. That byte comes from the target's current address.
- R8: Operation code 3 (random read) sends {1010, cmd_dev, 0} and the word address. It then issues a repeated start, sends {1010, cmd_dev, 1} and receives one byte from cmd_addr.
- R9: Operation code 4 (sequential read) runs the same address phases as R8 and then receives cmd_len bytes from consecutive addresses.
- R10: Each received byte is presented on rd_data (MSB received first) with rd_valid high for exactly one cycle.
- R11: When SDA is high on the ninth clock of any device, address or write-data byte, the controller sends a stop, requests no further write data and finishes with err = 1.
- R12: On the ninth clock of each received byte, the controller pulls SDA low. For the last byte of the read it leaves SDA high.
- R13: done is a one-cycle pulse at the end of each command. err keeps its value until the next command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Controller idle, command accepted this cycle if valid |
| cmd_op | input | 3 | 0 byte write, 1 page write, 2 current read, 3 random read, 4 sequential read |
| cmd_dev | input | 3 | Chip select bits of the device byte |
| cmd_addr | input | 8 | Word address |
| cmd_len | input | LEN_W | Byte count for page write and sequential read |
| div | input | DIV_W | SCL phase length minus two, in system clocks |
| wr_valid | input | 1 | Write byte offered |
| wr_data | input | 8 | Write byte |
| wr_ready | output | 1 | Controller waiting for a write byte |
| rd_valid | output | 1 | One-cycle strobe for rd_data |
| rd_data | output | 8 | Received byte |
| done | output | 1 | Command finished (pulse) |
| err | output | 1 | Last command refused or not acknowledged |
| scl_o | output | 1 | Serial clock level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_i | input | 1 | Sampled SDA bus level |

## Verification
A corrupted sequencing state tends to show up within one byte time, about 18 phases. It appears as a wrong count of start or stop conditions seen by the bus model, as a byte landing at the wrong address, or as a read returning the wrong word. A fault in the byte counter shows up differently. It appears in the number of write handshakes or received strobes. It also appears in the acknowledge pattern on the read's final byte, which the model counts as acknowledge versus no-acknowledge. Phase-counter faults change the measured SCL low time on the very first bit, so they become visible before any byte completes.

// File: rtl/eeprom_xact_ctrl.sv
module eeprom_xact_ctrl #(
  parameter int DIV_W = 12,
  parameter int LEN_W = 8,
  parameter int PAGE_MAX = 8,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic [2:0]       cmd_dev,
  input  logic [7:0]       cmd_addr,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic [DIV_W-1:0] div,
  input  logic             wr_valid,
  input  logic [7:0]       wr_data,
  output logic             wr_ready,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             done,
  output logic             err,
  output logic             scl_o,
  output logic             sda_oe,
  input  logic             sda_i
);

  localparam int PW = DIV_W + 1;
  localparam logic [2:0] OP_BW = 3'd0, OP_PW = 3'd1, OP_CR = 3'd2, OP_RR = 3'd3, OP_SR = 3'd4;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_DEVW, S_WADDR, S_GETD, S_DATA, S_RSTART, S_DEVR, S_READ, S_STOP
  } st_t;

  st_t             st;
  logic [2:0]      op_q, dev_q;
  logic [7:0]      addr_q, sh;
  logic [LEN_W-1:0] rem;
  logic [1:0]      ph;
  logic [PW-1:0]   pcnt;
  logic [3:0]      bitn;
  logic            sda_nx;

  wire [PW-1:0] plim   = {1'b0, div} + PW'(1);
  wire is_cond = (st == S_START) || (st == S_RSTART) || (st == S_STOP);
  wire is_tx   = (st == S_DEVW) || (st == S_WADDR) || (st == S_DATA) || (st == S_DEVR);
  wire is_rx   = (st == S_READ);
  wire running = is_cond || is_tx || is_rx;
  wire tick    = running && (pcnt == plim);
  wire last_ph = is_cond ? (ph == 2'd2) : (ph == 2'd1);
  wire sample  = tick && (is_tx || is_rx) && (ph == 2'd1);
  wire end_unit = tick && (is_cond ? (ph == 2'd2) : (ph == 2'd1 && bitn == 4'd8));
  wire is_read = (op_q == OP_CR) || (op_q == OP_RR) || (op_q == OP_SR);
  wire reject  = (cmd_op > OP_SR)
              || (cmd_op == OP_PW && (cmd_len == '0 || cmd_len > LEN_W'(PAGE_MAX)))
              || (cmd_op == OP_SR && cmd_len == '0);
  wire last_rd = (rem == LEN_W'(1));

  assign cmd_ready = (st == S_IDLE);
  assign wr_ready  = (st == S_GETD);
  assign scl_o     = (ph != 2'd0);

  always_comb begin
    sda_nx = 1'b0;
    case (st)
      S_START, S_RSTART: sda_nx = (ph == 2'd2);
      S_STOP:            sda_nx = (ph != 2'd2);
      S_DEVW, S_WADDR, S_DATA, S_DEVR: sda_nx = (bitn == 4'd8) ? 1'b0 : ~sh[7];
      S_READ:            sda_nx = (bitn == 4'd8) && !last_rd;
      default:           sda_nx = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; op_q <= OP_BW; dev_q <= '0; addr_q <= '0; sh <= '0; rem <= '0;
      ph <= 2'd2; pcnt <= '0; bitn <= '0; sda_oe <= 1'b0;
      done <= 1'b0; err <= 1'b0; rd_valid <= 1'b0; rd_data <= '0;
    end else begin
      sda_oe   <= sda_nx;
      done     <= 1'b0;
      rd_valid <= 1'b0;
      if (tick) begin
        pcnt <= '0;
        ph   <= last_ph ? 2'd0 : ph + 2'd1;
      end else if (running) begin
        pcnt <= pcnt + PW'(1);
      end
      if (sample) begin
        bitn <= (bitn == 4'd8) ? 4'd0 : bitn + 4'd1;
        if (bitn < 4'd8) sh <= {sh[6:0], sda_i};
      end
      case (st)
        S_IDLE: if (cmd_valid) begin
          err <= reject;
          if (reject) done <= 1'b1;
          else begin
            op_q <= cmd_op; dev_q <= cmd_dev; addr_q <= cmd_addr;
            rem  <= (cmd_op == OP_PW || cmd_op == OP_SR) ? cmd_len : LEN_W'(1);
            st <= S_START; ph <= 2'd0; pcnt <= '0; bitn <= '0;
          end
        end
        S_START: if (end_unit) begin
          if (op_q == OP_CR) begin st <= S_DEVR; sh <= {DEV_CODE, dev_q, 1'b1}; end
          else               begin st <= S_DEVW; sh <= {DEV_CODE, dev_q, 1'b0}; end
        end
        S_DEVW: if (end_unit) begin
          if (sda_i) begin err <= 1'b1; st <= S_STOP; end
          else begin st <= S_WADDR; sh <= addr_q; end
        end
        S_WADDR: if (end_unit) begin
          if (sda_i) begin err <= 1'b1; st <= S_STOP; end
          else if (is_read) st <= S_RSTART;
          else begin st <= S_GETD; ph <= 2'd1; end
        end
        S_GETD: if (wr_valid) begin
          sh <= wr_data; st <= S_DATA; ph <= 2'd0; pcnt <= '0;
        end
        S_DATA: if (end_unit) begin
          if (sda_i) begin err <= 1'b1; st <= S_STOP; end
          else begin
            rem <= rem - LEN_W'(1);
            if (last_rd) st <= S_STOP;
            else begin st <= S_GETD; ph <= 2'd1; end
          end
        end
        S_RSTART: if (end_unit) begin
          st <= S_DEVR; sh <= {DEV_CODE, dev_q, 1'b1};
        end
        S_DEVR: if (end_unit) begin
          if (sda_i) begin err <= 1'b1; st <= S_STOP; end
          else st <= S_READ;
        end
        S_READ: begin
          if (sample && bitn == 4'd7) begin
            rd_data  <= {sh[6:0], sda_i};
            rd_valid <= 1'b1;
          end
          if (end_unit) begin
            rem <= rem - LEN_W'(1);
            st  <= last_rd ? S_STOP : S_READ;
          end
        end
        S_STOP: if (end_unit) begin
          st <= S_IDLE; ph <= 2'd2; done <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [LEN_W:0] wcount;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wcount <= '0;
    else if (cmd_valid && cmd_ready) wcount <= '0;
    else if (wr_valid && wr_ready) wcount <= wcount + (LEN_W+1)'(1);
  end

  assert_idle_bus_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> (scl_o && !sda_oe));

  assert_sda_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((is_tx || is_rx) && scl_o && $past(scl_o) && ($past(st) == st)) |-> $stable(sda_oe));

  assert_page_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wcount <= (LEN_W+1)'(PAGE_MAX));

  assert_refuse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && reject) |=> (done && err && cmd_ready && scl_o));

  assert_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(st) == S_READ));

  assert_nack_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (is_tx && end_unit && sda_i) |=> ((st == S_STOP) && err));

  assert_read_ack_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rx && bitn == 4'd8 && scl_o) |-> (sda_oe == !last_rd));

  assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/sim_eeprom_xact_ctrl.sv
module sim_eeprom_xact_ctrl;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [2:0] cmd_op = '0, cmd_dev = '0;
  logic [7:0] cmd_addr = '0, cmd_len = '0;
  logic [11:0] div = 12'd3;
  logic wr_valid = 1'b1, wr_ready;
  logic [7:0] wr_data = '0;
  logic rd_valid, done, err, scl_o, sda_oe;
  logic [7:0] rd_data;
  logic slv_lo = 1'b0;
  wire sda_bus = ~(sda_oe | slv_lo);

  eeprom_xact_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_dev(cmd_dev), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .div(div), .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .err(err),
    .scl_o(scl_o), .sda_oe(sda_oe), .sda_i(sda_bus));

  int checks = 0, errors = 0;
  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bus target model, chip select 3'b101
  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  logic [7:0] ptr = '0, msh = '0;
  int mstate = 0, bc = 0;
  logic mack = 1'b0, nack_data = 1'b0;
  int starts = 0, stops = 0, macks = 0, mnacks = 0;

  always @(negedge sda_bus) if (scl_o === 1'b1) begin starts++; mstate = 1; bc = 0; slv_lo = 1'b0; end
  always @(posedge sda_bus) if (scl_o === 1'b1) begin stops++; mstate = 0; slv_lo = 1'b0; end

  always @(posedge scl_o) begin
    if (mstate >= 1 && mstate <= 3 && bc < 8) begin msh = {msh[6:0], sda_bus}; bc++; end
    else if (mstate == 4 && bc == 9) begin
      mack = !sda_bus;
      if (mack) macks++; else mnacks++;
    end
  end

  always @(negedge scl_o) begin
    if (mstate >= 1 && mstate <= 3) begin
      if (bc == 8) begin
        bc = 9;
        if (mstate == 1) begin
          if (msh[7:1] == 7'b1010101) slv_lo = 1'b1; else mstate = 0;
        end else if (mstate == 2) begin ptr = msh; slv_lo = 1'b1; end
        else if (!nack_data) begin mem[ptr] = msh; ptr++; slv_lo = 1'b1; end
      end else if (bc == 9) begin
        slv_lo = 1'b0; bc = 0;
        if (mstate == 1 && msh[0]) begin
          mstate = 4; msh = mem[ptr]; ptr++;
          slv_lo = !msh[7]; msh = {msh[6:0], 1'b0}; bc = 1;
        end else if (mstate == 1) mstate = 2;
        else if (mstate == 2) mstate = 3;
      end
    end else if (mstate == 4) begin
      if (bc < 8) begin slv_lo = !msh[7]; msh = {msh[6:0], 1'b0}; bc++; end
      else if (bc == 8) begin slv_lo = 1'b0; bc = 9; end
      else if (mack) begin
        msh = mem[ptr]; ptr++; slv_lo = !msh[7]; msh = {msh[6:0], 1'b0}; bc = 1;
      end else begin mstate = 0; slv_lo = 1'b0; end
    end
  end

  // phase monitor, sampled 2 ns after the rising clock edge
  int lowrun = 0, lowmin = 0, lowmax = 0, sclfalls = 0;
  logic scl_prev = 1'b1;
  always @(posedge clk) begin
    #2;
    if (!scl_o) lowrun++;
    else if (lowrun > 0) begin
      if (lowrun < lowmin) lowmin = lowrun;
      if (lowrun > lowmax) lowmax = lowrun;
      lowrun = 0;
    end
    if (scl_prev && !scl_o) sclfalls++;
    scl_prev = scl_o;
  end

  // write supply and read capture
  function automatic logic [7:0] pat(int v, int k);
    return 8'(v * 16 + k * 3 + 145);
  endfunction
  int wr_cnt = 0, wr_base = 0, rd_cnt = 0;
  logic [7:0] rd_buf [16];
  always @(negedge clk) begin
    if (wr_ready) begin wr_data = pat(wr_base, wr_cnt); wr_cnt++; end
    if (rd_valid) begin
      if (rd_cnt < 16) rd_buf[rd_cnt] = rd_data;
      rd_cnt++;
    end
  end

  logic got_err;
  int cur = 0;

  task automatic run(input logic [2:0] op, input logic [2:0] dev, input logic [7:0] addr,
                     input logic [7:0] len, input int base);
    int cyc;
    @(posedge clk); #1;
    wr_cnt = 0; rd_cnt = 0; wr_base = base; starts = 0; stops = 0; macks = 0; mnacks = 0;
    lowrun = 0; lowmin = 1000000; lowmax = 0; sclfalls = 0;
    @(negedge clk);
    cmd_op = op; cmd_dev = dev; cmd_addr = addr; cmd_len = len; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    cyc = 0;
    while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
    check(done == 1'b1, "R13 done seen", int'(done), 1);
    got_err = err;
    @(negedge clk);
    check(done == 1'b0 && err == got_err, "R13 done pulse, err held", int'({done, err}), int'({1'b0, got_err}));
  endtask

  localparam int NV = 10;
  localparam logic [22:0] VEC [NV] = '{
    {3'd0, 3'd5, 8'h10, 8'd1, 1'b0},
    {3'd1, 3'd5, 8'h20, 8'd8, 1'b0},
    {3'd3, 3'd5, 8'h10, 8'd1, 1'b0},
    {3'd2, 3'd5, 8'h00, 8'd1, 1'b0},
    {3'd4, 3'd5, 8'h1E, 8'd5, 1'b0},
    {3'd1, 3'd5, 8'h40, 8'd3, 1'b0},
    {3'd4, 3'd5, 8'h3F, 8'd4, 1'b0},
    {3'd0, 3'd3, 8'h50, 8'd1, 1'b1},
    {3'd3, 3'd2, 8'h50, 8'd1, 1'b1},
    {3'd2, 3'd5, 8'h00, 8'd1, 1'b0}
  };

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i) ^ 8'h5A;
      exp_mem[i] = 8'(i) ^ 8'h5A;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    mstate = 0; slv_lo = 1'b0;
    check(scl_o == 1'b1 && sda_oe == 1'b0, "R1 bus released after reset", int'({scl_o, sda_oe}), 2);
    check(cmd_ready && !done && !err, "R1 idle outputs", int'({cmd_ready, done, err}), 4);

    for (int v = 0; v < NV; v++) begin
      logic [2:0] op;
      logic [7:0] ad, ln;
      int n, first;
      bit e;
      op = VEC[v][22:20]; ad = VEC[v][16:9]; ln = VEC[v][8:1]; e = VEC[v][0];
      n = (op == 3'd1 || op == 3'd4) ? int'(ln) : 1;
      first = (op == 3'd2) ? cur : int'(ad);
      run(op, VEC[v][19:17], ad, ln, v);
      check(got_err == e, "R11 error flag", int'(got_err), int'(e));
      check(stops == 1, "R2 one stop", stops, 1);
      check(starts == ((!e && (op == 3'd3 || op == 3'd4)) ? 2 : 1), "R2 start count", starts,
            (!e && (op == 3'd3 || op == 3'd4)) ? 2 : 1);
      check(lowmin == 5 && lowmax == 5, "R3 low phase length", lowmax, 5);
      check(scl_o && sda_bus, "R1 bus idle after command", int'({scl_o, sda_bus}), 3);
      if (op <= 3'd1) begin
        check(wr_cnt == (e ? 0 : n), "R4 R5 R11 write handshakes", wr_cnt, e ? 0 : n);
        if (!e) begin
          for (int k = 0; k < n; k++) begin
            exp_mem[8'(first + k)] = pat(v, k);
            check(mem[8'(first + k)] == pat(v, k), op == 3'd0 ? "R4 byte written" : "R5 page byte written",
                  int'(mem[8'(first + k)]), int'(pat(v, k)));
          end
          cur = (first + n) % 256;
        end
      end else begin
        check(rd_cnt == (e ? 0 : n), "R10 read strobes", rd_cnt, e ? 0 : n);
        if (!e) begin
          for (int k = 0; k < n; k++)
            check(rd_buf[k] == exp_mem[8'(first + k)],
                  op == 3'd2 ? "R7 current read data" : (op == 3'd3 ? "R8 random read data" : "R9 sequential data"),
                  int'(rd_buf[k]), int'(exp_mem[8'(first + k)]));
          check(macks == n - 1 && mnacks == 1, "R12 ack pattern", macks * 16 + mnacks, (n - 1) * 16 + 1);
          cur = (first + n) % 256;
        end
      end
    end

    // R6 refused commands
    run(3'd1, 3'd5, 8'h70, 8'd9, 20);
    check(got_err && sclfalls == 0 && starts == 0, "R6 page count 9 refused", sclfalls, 0);
    run(3'd1, 3'd5, 8'h70, 8'd0, 21);
    check(got_err && sclfalls == 0 && wr_cnt == 0, "R6 page count 0 refused", sclfalls, 0);
    run(3'd7, 3'd5, 8'h70, 8'd1, 22);
    check(got_err && sclfalls == 0, "R6 bad opcode refused", int'(got_err), 1);
    run(3'd4, 3'd5, 8'h70, 8'd0, 23);
    check(got_err && sclfalls == 0 && rd_cnt == 0, "R6 sequential count 0 refused", sclfalls, 0);

    // R11 data byte not acknowledged
    nack_data = 1'b1;
    run(3'd1, 3'd5, 8'h60, 8'd4, 24);
    nack_data = 1'b0;
    check(got_err == 1'b1, "R11 data nack error", int'(got_err), 1);
    check(wr_cnt == 1, "R11 no further data requested", wr_cnt, 1);
    check(stops == 1, "R11 stop after nack", stops, 1);
    check(mem[8'h60] == exp_mem[8'h60], "R11 data not stored", int'(mem[8'h60]), int'(exp_mem[8'h60]));

    // R3 other phase lengths
    div = 12'd0;
    run(3'd0, 3'd5, 8'h80, 8'd1, 25);
    check(lowmin == 2 && lowmax == 2, "R3 div 0 low phase", lowmax, 2);
    check(mem[8'h80] == pat(25, 0), "R4 byte write at div 0", int'(mem[8'h80]), int'(pat(25, 0)));
    exp_mem[8'h80] = pat(25, 0);
    div = 12'd7;
    run(3'd3, 3'd5, 8'h80, 8'd1, 26);
    check(lowmin == 9 && lowmax == 9, "R3 div 7 low phase", lowmax, 9);
    check(rd_buf[0] == exp_mem[8'h80], "R8 random read at div 7", int'(rd_buf[0]), int'(exp_mem[8'h80]));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule